// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast reference clock into the single-cycle enable that paces a UART's 16x oversampling logic. The reference is first cut down by an integer pre-divider, chosen from a 3-bit code. The result then drives a fractional stage whose rate is a programmable ratio, numerator over denominator. The fractional stage is a phase accumulator. On every pre-divided clock it adds the numerator, and each time the sum reaches the denominator it removes the denominator and issues a tick.

Software programs three registers through a simple write port: the pre-divider code, the numerator and the denominator. The pre-divider code applies at once. The numerator and denominator are guarded: a new ratio is taken only when a numerator write is followed, as the very next write, by a denominator write. The pair then loads together and the generator restarts its phase from zero. Both ratio registers hold their value minus one. A numerator register of 15 with a denominator register of (reference/baud − 1) therefore yields ticks at 16 times the requested baud.

Top module: `fbg_baud_gen`

## Requirements
- R1: While `rst` is high `tick` is low. After reset the pre-divider code is 5 (ratio 1), the numerator register is 15 and the denominator register is 0, so a tick is issued on every clock.
- R2: A write with `wr_sel` = 0 loads the pre-divider code from `wr_data[2:0]`. Codes 0,1,2,3,4,5,6,7 divide the clock by 6,5,4,3,2,1,7,1 respectively.
- R3: The ratio registers hold value minus one. After a restart, the number of ticks seen over the first m pre-divided clocks is floor(m·(N+1)/(D+1)), where N is the numerator register and D the denominator register, as long as N < D.
- R4: When N ≥ D the fractional stage saturates and issues exactly one tick per pre-divided clock.
- R5: A numerator write (`wr_sel` = 1) followed, as the next write, by a denominator write (`wr_sel` = 2) loads both values at the denominator write's clock edge. The same edge clears the accumulator and the pre-divider count, so the first pre-divided clock falls `ratio` cycles later.
- R6: A pending numerator is discarded if the next write goes to any other select (0 or 3). A denominator write with no pending numerator is ignored. Neither case changes the running tick rate.
- R7: A second numerator write replaces the pending value, and the following denominator write applies the latest numerator.
- R8: A pre-divider write restarts the count, clearing the accumulator and the pre-divider counter, in the same way as R5.
- R9: `tick` is high only in the cycle after a pre-divided clock. The accumulator stays below D+1 at all times.
- R10: With code 5, N = 15 and D = reference/baud − 1, the generator gives 16 ticks every reference/baud clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle it is high |
| wr_sel | input | 2 | Register select: 0 pre-divider, 1 numerator, 2 denominator, 3 unused |
| wr_data | input | DIV_W | Write data; only the low 3 bits matter for the pre-divider |
| tick | output | 1 | Single-cycle enable at 16x the baud rate |

## Verification
The pre-divider is run through all eight codes with a unit ratio. Each code's tick count over a fixed window shows its divide ratio, which exposes any swapped entry in the non-monotonic map. Fractional ratios are measured over full windows and over short windows that end mid-cycle, which separates correct floor behaviour and a cleared starting phase from an accumulator that keeps a stale remainder. Write sequences are interleaved before measurement: a lone numerator, a lone denominator, an intervening pre-divider write, and a repeated numerator. Each sequence is chosen so that an accepted bad write would produce a different count from the rejected one. A saturating ratio with N above D and the standard console setting complete the set.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  typedef enum logic [1:0] {
    SEL_PRE = 2'd0,
    SEL_NUM = 2'd1,
    SEL_DEN = 2'd2,
    SEL_RSV = 2'd3
  } fbg_sel_e;

  localparam int PRE_W         = 3;
  localparam logic [PRE_W-1:0] PRE_CODE_RESET = 3'd5;
  localparam int NUM_RESET     = 15;
  localparam int DEN_RESET     = 0;

  // Non-monotonic code to divide-ratio map (R2).
  function automatic logic [PRE_W-1:0] pre_ratio(input logic [PRE_W-1:0] code);
    case (code)
      3'd0:    return 3'd6;
      3'd1:    return 3'd5;
      3'd2:    return 3'd4;
      3'd3:    return 3'd3;
      3'd4:    return 3'd2;
      3'd6:    return 3'd7;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  fbg_sel_e         wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic [PRE_W-1:0] pre_code,
  output logic [DIV_W-1:0] num_q,
  output logic [DIV_W-1:0] den_q,
  output logic             pend_v,
  output logic             apply,
  output logic             restart
);

  logic [DIV_W-1:0] pend_num;
  logic             pre_wr;

  assign apply   = wr_en && (wr_sel == SEL_DEN) && pend_v;
  assign pre_wr  = wr_en && (wr_sel == SEL_PRE);
  assign restart = apply || pre_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_code <= PRE_CODE_RESET;
      num_q    <= DIV_W'(NUM_RESET);
      den_q    <= DIV_W'(DEN_RESET);
      pend_num <= '0;
      pend_v   <= 1'b0;
    end else if (wr_en) begin
      // Every write ends the pairing window; only a numerator reopens it.
      pend_v <= (wr_sel == SEL_NUM);
      if (wr_sel == SEL_NUM) pend_num <= wr_data;
      if (pre_wr) pre_code <= wr_data[PRE_W-1:0];
      if (apply) begin
        num_q <= pend_num;
        den_q <= wr_data;
      end
    end
  end

endmodule

// File: rtl/fbg_prescale.sv
module fbg_prescale
  import fbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_code,
  output logic [PRE_W-1:0] ratio,
  output logic [PRE_W-1:0] cnt,
  output logic             pre_tick
);

  assign ratio    = pre_ratio(pre_code);
  assign pre_tick = (cnt == ratio - 3'd1);

  always_ff @(posedge clk) begin
    if (rst || restart)   cnt <= '0;
    else if (pre_tick)    cnt <= '0;
    else                  cnt <= cnt + 3'd1;
  end

endmodule

// File: rtl/fbg_accum.sv
module fbg_accum #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             pre_tick,
  input  logic [DIV_W-1:0] num_q,
  input  logic [DIV_W-1:0] den_q,
  output logic [DIV_W:0]   num1,
  output logic [DIV_W:0]   den1,
  output logic [DIV_W:0]   acc_q,
  output logic             tick
);

  localparam int ACC_W = DIV_W + 1;

  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic             hit;
  } step_t;

  // One phase step: add the numerator, wrap at the denominator (R3, R4).
  function automatic step_t frac_step(input logic [ACC_W-1:0] acc,
                                      input logic [ACC_W-1:0] n1,
                                      input logic [ACC_W-1:0] d1);
    step_t          r;
    logic [ACC_W:0] sum;
    sum = {1'b0, acc} + {1'b0, n1};
    if (n1 >= d1) begin
      r.acc = '0;
      r.hit = 1'b1;
    end else if (sum >= {1'b0, d1}) begin
      r.acc = ACC_W'(sum - {1'b0, d1});
      r.hit = 1'b1;
    end else begin
      r.acc = ACC_W'(sum);
      r.hit = 1'b0;
    end
    return r;
  endfunction

  step_t nxt;

  assign num1 = {1'b0, num_q} + ACC_W'(1);
  assign den1 = {1'b0, den_q} + ACC_W'(1);
  assign nxt  = frac_step(acc_q, num1, den1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (pre_tick) begin
      acc_q <= nxt.acc;
      tick  <= nxt.hit;
    end else begin
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/fbg_baud_gen.sv
module fbg_baud_gen
  import fbg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic             tick
);

  logic [PRE_W-1:0] pre_code;
  logic [PRE_W-1:0] ratio;
  logic [PRE_W-1:0] cnt;
  logic [DIV_W-1:0] num_q;
  logic [DIV_W-1:0] den_q;
  logic [DIV_W:0]   num1;
  logic [DIV_W:0]   den1;
  logic [DIV_W:0]   acc_q;
  logic             pend_v;
  logic             apply;
  logic             restart;
  logic             pre_tick;
  fbg_sel_e         sel_e;

  assign sel_e = fbg_sel_e'(wr_sel);

  fbg_regs #(.DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (sel_e),
    .wr_data (wr_data),
    .pre_code(pre_code),
    .num_q   (num_q),
    .den_q   (den_q),
    .pend_v  (pend_v),
    .apply   (apply),
    .restart (restart)
  );

  fbg_prescale u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .pre_code(pre_code),
    .ratio   (ratio),
    .cnt     (cnt),
    .pre_tick(pre_tick)
  );

  fbg_accum #(.DIV_W(DIV_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .pre_tick(pre_tick),
    .num_q   (num_q),
    .den_q   (den_q),
    .num1    (num1),
    .den1    (den1),
    .acc_q   (acc_q),
    .tick    (tick)
  );

endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             tick,
  input logic             pre_tick,
  input logic             apply,
  input logic             restart,
  input logic             pend_v,
  input logic [2:0]       cnt,
  input logic [2:0]       ratio,
  input logic [DIV_W:0]   num1,
  input logic [DIV_W:0]   den1,
  input logic [DIV_W:0]   acc_q
);

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !tick);

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt < ratio);

  a_r3_acc_below_den: assert property (@(posedge clk) disable iff (rst)
    acc_q < den1);

  a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
    (pre_tick && !restart && num1 >= den1) |=> tick);

  a_r5_apply_clears: assert property (@(posedge clk) disable iff (rst)
    apply |=> (acc_q == '0) && (cnt == '0));

  a_r6_lone_den: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2 && !pend_v) |=> ($stable(den1) && $stable(num1)));

  a_r9_tick_after_pre: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(pre_tick) && !$past(restart)));

endmodule

bind fbg_baud_gen fbg_checker #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .tick    (tick),
  .pre_tick(pre_tick),
  .apply   (apply),
  .restart (restart),
  .pend_v  (pend_v),
  .cnt     (cnt),
  .ratio   (ratio),
  .num1    (num1),
  .den1    (den1),
  .acc_q   (acc_q)
);

// File: tb/sim_fbg_baud_gen.sv
module sim_fbg_baud_gen;

  localparam int PERIOD = 10;
  localparam int DIV_W  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = 2'd0;
  logic [DIV_W-1:0] wr_data = '0;
  logic             tick;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_cnt = 0;
  bit done     = 1'b0;
  int exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  fbg_baud_gen #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick)
  );

  // Monitor: accumulates ticks away from the active edge.
  always @(negedge clk) if (!rst) tick_cnt += int'(tick);

  function automatic int ratio_of(input int code);
    int tbl[8] = '{6, 5, 4, 3, 2, 1, 7, 1};
    return tbl[code];
  endfunction

  // Expected ticks over k clocks after a restart.
  function automatic int want(input int k, input int r, input int n, input int d);
    longint m = k / r;
    if (n >= d) return int'(m);
    return int'((m * (n + 1)) / (d + 1));
  endfunction

  task automatic report(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = DIV_W'(data);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // Driver pushes the expectation; the window result is popped and compared.
  task automatic window(input int k, input int exp, input string tag);
    int base;
    exp_q.push_back(exp);
    base = tick_cnt;
    repeat (k) @(posedge clk);
    #(PERIOD/2 + 1);
    report(tag, tick_cnt - base, exp_q.pop_front());
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk) report("R1 tick low in reset", int'(tick), 0);
    @(posedge clk); #1 rst = 1'b0;
    window(10, 10, "R1 reset setting ticks every clock");

    // R2: all codes with unit ratio
    wr(2'd1, 15); wr(2'd2, 15);
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, c);
      window(42, want(42, ratio_of(c), 15, 15), $sformatf("R2 code %0d", c));
    end

    // R3 / R5: fractional 3/10, code 5
    wr(2'd0, 5);
    wr(2'd1, 2); wr(2'd2, 9);
    window(7, want(7, 1, 2, 9), "R3 R5 short window 3/10");
    wr(2'd1, 2); wr(2'd2, 9);
    window(100, want(100, 1, 2, 9), "R3 long window 3/10");

    // R5 restart timing with ratio 3 and fraction 5/8
    wr(2'd0, 3);
    wr(2'd1, 4); wr(2'd2, 7);
    window(2, 0, "R5 no tick before first pre clock");
    wr(2'd1, 4); wr(2'd2, 7);
    window(48, want(48, 3, 4, 7), "R5 ratio 3 fraction 5/8");

    // R6: discarded numerator and lone denominator keep 5/8 at ratio 3
    wr(2'd1, 7); wr(2'd0, 3); wr(2'd2, 0); wr(2'd0, 3);
    window(48, want(48, 3, 4, 7), "R6 lone writes ignored");
    wr(2'd1, 7); wr(2'd3, 0); wr(2'd2, 0); wr(2'd0, 3);
    window(48, want(48, 3, 4, 7), "R6 select 3 discards pending");

    // R7: second numerator replaces the first
    wr(2'd0, 5);
    wr(2'd1, 0); wr(2'd1, 6); wr(2'd2, 9);
    window(50, want(50, 1, 6, 9), "R7 latest numerator applied");

    // R8: pre-divider write restarts counting
    wr(2'd0, 4);
    window(1, 0, "R8 restart holds first tick");
    wr(2'd0, 4);
    window(40, want(40, 2, 6, 9), "R8 ratio 2 with 7/10");

    // R4: saturation when N > D
    wr(2'd0, 2);
    wr(2'd1, 20); wr(2'd2, 3);
    window(40, want(40, 4, 20, 3), "R4 saturated one per pre clock");

    // R10: 24x reference over baud, numerator 15
    wr(2'd0, 5);
    wr(2'd1, 15); wr(2'd2, 23);
    window(48, want(48, 1, 15, 23), "R10 sixteen per 24 clocks");
    report("R10 closed form", want(48, 1, 15, 23), 32);

    // R9: single-cycle ticks with a slow ratio
    wr(2'd0, 6);
    wr(2'd1, 0); wr(2'd2, 0);
    window(14, 2, "R9 ticks only after pre clock");

    finish_run();
  end

endmodule